// File: doc/BRIEF.md
# Edge-Selectable Line Clamp Pulse Generator

This block produces one active-high clamp pulse per scan line for a display front end. The pulse is anchored either to the leading edge or to the trailing edge of the horizontal sync that also drives the horizontal drive output. That sync arrives already normalised to positive polarity, so its leading edge is a rising transition and its trailing edge a falling one. Along with it come a bit that says whether any horizontal source is present and a bit that says whether that source is sync-on-video. The source priority itself is resolved upstream: the composite or separate horizontal input is taken first, and sync-on-video only when that input is missing.

A two-bit select chooses the anchor edge. One code forces the back edge and one forces the front edge. The third setting chooses automatically: it takes the front edge for a separate or composite sync source and the back edge for sync-on-video. The pulse width is a count of system clock cycles, which takes the place of an external timing network. A clock of about 100 MHz with a count near 40 gives the usual width of roughly 400 ns.

Top module: `clamp_pulse_gen`

## Requirements
- R1: During and after reset `clampOut` is low. It stays low until a qualifying sync edge is seen.
- R2: With `edgeSel` = 01 (front edge), the first clock edge that samples `syncIn` high after it was sampled low drives `clampOut` high at that same edge.
- R3: With `edgeSel` = 00 (back edge), the first clock edge that samples `syncIn` low after it was sampled high drives `clampOut` high at that same edge.
- R4: With `edgeSel` = 1x (automatic) and `srcVideo` = 0, the pulse starts on the rising sync transition, exactly as in R2.
- R5: With `edgeSel` = 1x and `srcVideo` = 1, the pulse starts on the falling sync transition, exactly as in R3.
- R6: Once started, `clampOut` stays high for exactly N clock cycles and then goes low. N is the value of `pulseWidth` sampled at the clock edge that started the pulse.
- R7: A `pulseWidth` of 0 gives a pulse that is one cycle long.
- R8: A qualifying edge that arrives while `clampOut` is high is ignored. It neither restarts the pulse nor lengthens it.
- R9: A sync edge sampled while `srcValid` is low starts no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| syncIn | input | 1 | Selected horizontal sync, positive polarity |
| srcValid | input | 1 | High when a horizontal source is present |
| srcVideo | input | 1 | High when the source is sync-on-video, low for separate or composite sync |
| edgeSel | input | 2 | 00 back edge, 01 front edge, 1x automatic |
| pulseWidth | input | WIDTH_W (8) | Pulse width in clock cycles (0 is treated as 1) |
| clampOut | output | 1 | Clamp pulse, active high |

## Verification
The hardest case to reach from the ports is a sync edge that arrives during the last high cycle of a pulse, when the internal count has just reached zero. That edge must still be ignored, and the pulse must end on time. The stimulus gets there with directed sequences that toggle the sync at computed offsets from the pulse start. Random runs with short widths and frequent sync toggles then land many edges inside and right at the end of active pulses. Under the automatic select setting, `srcVideo` is changed between lines so that the edge choice flips while everything else stays the same.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

  typedef enum logic [0:0] {
    EDGE_BACK  = 1'b0,
    EDGE_FRONT = 1'b1
  } edge_mode_e;

  typedef struct packed {
    logic load;
    logic dec;
    logic clear;
  } clamp_strobes_t;

endpackage

// File: rtl/clamp_ctrl.sv
module clamp_ctrl
  import clamp_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           syncIn,
  input  logic           srcValid,
  input  logic           srcVideo,
  input  logic [1:0]     edgeSel,
  input  logic           pulseActive,
  input  logic           cntZero,
  output clamp_strobes_t strobes
);

  logic       syncQ;
  logic       riseEv;
  logic       fallEv;
  logic       edgeHit;
  edge_mode_e activeMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 1'b0;
    else       syncQ <= syncIn;
  end

  assign riseEv = syncIn & ~syncQ;
  assign fallEv = ~syncIn & syncQ;

  // automatic select: leading edge for separate/composite, trailing for video
  always_comb begin
    if (edgeSel[1]) activeMode = srcVideo ? EDGE_BACK : EDGE_FRONT;
    else            activeMode = edgeSel[0] ? EDGE_FRONT : EDGE_BACK;
  end

  assign edgeHit = (activeMode == EDGE_FRONT) ? riseEv : fallEv;

  always_comb begin
    strobes.load  = !pulseActive && srcValid && edgeHit;
    strobes.dec   = pulseActive && !cntZero;
    strobes.clear = pulseActive && cntZero;
  end

  p_no_src_r9: assert property (@(posedge clk) disable iff (!rstN)
    !srcValid |-> !strobes.load);

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    pulseActive |-> !strobes.load);

  p_front_level_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && edgeSel == 2'b01) |-> syncIn);

  p_back_level_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && edgeSel == 2'b00) |-> !syncIn);

  p_auto_video_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && edgeSel[1] && srcVideo) |-> !syncIn);

  p_auto_hsync_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && edgeSel[1] && !srcVideo) |-> syncIn);

endmodule

// File: rtl/clamp_dpath.sv
module clamp_dpath
  import clamp_pkg::*;
#(
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  clamp_strobes_t     strobes,
  input  logic [WIDTH_W-1:0] pulseWidth,
  output logic               clampOut,
  output logic               cntZero
);

  localparam logic [WIDTH_W-1:0] ZERO_CNT = '0;
  localparam logic [WIDTH_W-1:0] ONE_CNT  = WIDTH_W'(1);

  logic [WIDTH_W-1:0] remCnt;
  logic [WIDTH_W-1:0] loadVal;

  // zero width behaves as one cycle: reload value is width-1, floored at 0
  assign loadVal = (pulseWidth == ZERO_CNT) ? ZERO_CNT : pulseWidth - ONE_CNT;
  assign cntZero = (remCnt == ZERO_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clampOut <= 1'b0;
      remCnt   <= ZERO_CNT;
    end else if (strobes.load) begin
      clampOut <= 1'b1;
      remCnt   <= loadVal;
    end else if (strobes.clear) begin
      clampOut <= 1'b0;
    end else if (strobes.dec) begin
      remCnt   <= remCnt - ONE_CNT;
    end
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> clampOut);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clampOut && !cntZero) |=> clampOut);

  p_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clampOut && cntZero) |=> !clampOut);

  p_min_width_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && pulseWidth == ZERO_CNT) |=> (clampOut && cntZero));

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!clampOut && !strobes.load) |=> !clampOut);

endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
  import clamp_pkg::*;
#(
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               syncIn,
  input  logic               srcValid,
  input  logic               srcVideo,
  input  logic [1:0]         edgeSel,
  input  logic [WIDTH_W-1:0] pulseWidth,
  output logic               clampOut
);

  clamp_strobes_t strobes;
  logic           cntZero;

  clamp_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .syncIn     (syncIn),
    .srcValid   (srcValid),
    .srcVideo   (srcVideo),
    .edgeSel    (edgeSel),
    .pulseActive(clampOut),
    .cntZero    (cntZero),
    .strobes    (strobes)
  );

  clamp_dpath #(.WIDTH_W(WIDTH_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .pulseWidth(pulseWidth),
    .clampOut  (clampOut),
    .cntZero   (cntZero)
  );

endmodule

// File: tb/sim_clamp_pulse_gen.sv
module sim_clamp_pulse_gen;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH_W    = 8;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               syncIn = 1'b0;
  logic               srcValid = 1'b0;
  logic               srcVideo = 1'b0;
  logic [1:0]         edgeSel = 2'b01;
  logic [WIDTH_W-1:0] pulseWidth = '0;
  logic               clampOut;

  int vecCount = 0;
  int errCount = 0;
  bit finished = 1'b0;

  // reference model state
  bit    mActive = 1'b0;
  int    mCnt = 0;
  bit    mPrev = 1'b0;
  string curTag = "R2";

  clamp_pulse_gen #(.WIDTH_W(WIDTH_W)) u0 (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .srcValid(srcValid),
    .srcVideo(srcVideo), .edgeSel(edgeSel), .pulseWidth(pulseWidth),
    .clampOut(clampOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit useFront(input logic [1:0] sel, input bit video);
    if (sel[1]) return !video;
    return sel[0];
  endfunction

  function automatic string modeTag(input logic [1:0] sel, input bit video);
    if (sel == 2'b01) return "R2";
    if (sel == 2'b00) return "R3";
    return video ? "R5" : "R4";
  endfunction

  task automatic check(input bit exp, input string tag);
    vecCount++;
    if (clampOut !== exp) begin
      errCount++;
      $display("FAIL %s: clampOut=%0b expected=%0b at %0t", tag, clampOut, exp, $time);
    end
  endtask

  // drive at negedge, advance model, sample at next negedge
  task automatic step(input bit s, input bit v, input bit vid,
                      input logic [1:0] sel, input int w);
    bit edgeOk;
    bit exp;
    string tag;
    syncIn = s; srcValid = v; srcVideo = vid; edgeSel = sel;
    pulseWidth = WIDTH_W'(w);
    edgeOk = useFront(sel, vid) ? (s && !mPrev) : (!s && mPrev);
    if (mActive) begin
      if (mCnt == 0) mActive = 1'b0;
      else begin
        mCnt--;
        curTag = (w == 0) ? curTag : curTag;
        if (curTag != "R7") curTag = "R6";
      end
    end else if (edgeOk && v) begin
      mActive = 1'b1;
      mCnt = (w == 0) ? 0 : w - 1;
      curTag = (w == 0) ? "R7" : modeTag(sel, vid);
    end
    mPrev = s;
    exp = mActive;
    if (exp) tag = curTag;
    else tag = v ? "R8" : "R9";
    @(posedge clk);
    @(negedge clk);
    check(exp, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errCount++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(1'b0, "R1");
    rstN = 1'b1;
    @(negedge clk);
    check(1'b0, "R1");

    // R2: front edge, width 4
    step(0,1,0,2'b01,4);
    step(1,1,0,2'b01,4);
    for (int i = 0; i < 6; i++) step(1,1,0,2'b01,4);
    // R3: back edge, width 3
    step(0,1,0,2'b00,3);
    for (int i = 0; i < 5; i++) step(0,1,0,2'b00,3);
    step(1,1,0,2'b00,3);
    step(0,1,0,2'b00,3);
    for (int i = 0; i < 4; i++) step(0,1,0,2'b00,3);
    // R4 and R5: automatic selection by source type
    step(1,1,0,2'b10,2);
    for (int i = 0; i < 3; i++) step(1,1,0,2'b10,2);
    step(0,1,1,2'b11,2);
    for (int i = 0; i < 3; i++) step(0,1,1,2'b11,2);
    step(1,1,1,2'b11,2);
    for (int i = 0; i < 3; i++) step(1,1,1,2'b11,2);
    // R7: zero width gives one cycle
    step(0,1,0,2'b01,0);
    step(1,1,0,2'b01,0);
    step(1,1,0,2'b01,0);
    step(1,1,0,2'b01,0);
    // R8: edges during the pulse, including its final cycle
    step(0,1,0,2'b01,3);
    step(1,1,0,2'b01,3);
    step(0,1,0,2'b01,3);
    step(1,1,0,2'b01,3);
    step(0,1,0,2'b01,3);
    step(0,1,0,2'b01,3);
    // R9: no source present
    step(1,0,0,2'b01,5);
    step(0,0,0,2'b01,5);
    step(1,0,0,2'b01,5);
    step(1,0,0,2'b01,5);
    // R6: long pulse
    step(0,1,0,2'b01,20);
    for (int i = 0; i < 24; i++) step(1,1,0,2'b01,20);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit s  = ($urandom_range(0, 3) == 0) ? !syncIn : syncIn;
      bit v  = ($urandom_range(0, 9) != 0);
      bit vd = ($urandom_range(0, 3) == 0) ? !srcVideo : srcVideo;
      logic [1:0] sl = ($urandom_range(0, 15) == 0) ? 2'($urandom_range(0, 3)) : edgeSel;
      int w = $urandom_range(0, 9);
      step(s, v, vd, sl, w);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule